// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned N-bit operands and a carry-in in one combinational pass. It returns an N-bit sum and a carry-out. The carries come from a logarithmic-depth prefix network, not a rippled chain. The delay from any input to any output therefore grows with log2 N rather than with N.

The work is split into three stages:

1. Each bit position forms a local carry-generate term (both operand bits set) and a carry-propagate term (operand bits differ).
2. A prefix tree merges these terms over ever wider spans. The carry-in takes the lowest tree slot as a pure generate with propagate forced low. After log2 N levels, every slot holds the carry into its bit.
3. Each sum bit is the local propagate XOR the carry into that bit. One extra merge cell past the tree gives the carry-out.

At tree level k, each slot merges with the slot 2^k positions below it. Once a slot's span reaches the carry-in, only its generate term is formed from then on. Slots below 2^k pass straight through. No node drives more than two loads.

Top module: `ppx_adder`

## Requirements
- R1: For every input, the value {cout, sum} equals the arithmetic value a + b + cin at the default width of 16.
- R2: The width parameter N may be any power of two of at least 2; at N = 4 the result equals a + b + cin for all 512 combinations of a, b and cin.
- R3: With a and b differing in every bit (for example a all ones and b zero) and cin = 1, the carry travels the full width: sum is all zeros and cout is 1.
- R4: With b = 0 and cin = 0, sum equals a and cout is 0.
- R5: When a and b both have their most significant bit set, cout is 1 whatever the lower bits and cin.
- R6: When a and b both have their most significant bit clear, cout is 0 whatever the lower bits and cin.
- R7: With a = 0, b = 0 and cin = 1, sum equals 1 (only bit 0 set) and cout is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand, unsigned |
| b | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
The hardest case to reach is a carry that must cross every prefix level from the carry-in slot to the top bit. This needs every position to propagate and none to generate or kill. Random 16-bit operands hit that with a chance of about one in 65,000 per vector, so the stimulus sets it up directly: all-ones plus zero, and alternating patterns with their complements, each with cin = 1. A 4-bit copy of the adder is driven over its whole input space. That walks every buffer, generate-only and full merge cell of a smaller tree through all of its input combinations.

// File: rtl/ppx_pkg.sv
// Package: ppx_pkg
// Shared helpers for the prefix adder: tree depth and width legality.
// Assumes widths are small positive integers known at elaboration.
package ppx_pkg;

    // Number of prefix levels needed to cover n slots (ceiling log2).
    function automatic int unsigned tree_levels(input int unsigned n);
        int unsigned lv;
        lv = 0;
        while ((32'd1 << lv) < n) lv++;
        return lv;
    endfunction

    // True when n is a power of two of at least 2.
    function automatic bit width_is_legal(input int unsigned n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/ppx_pg_bitwise.sv
// Module: ppx_pg_bitwise
// Forms the per-bit carry generate (both bits set) and propagate
// (bits differ) terms. Purely combinational; assumes N >= 1.
module ppx_pg_bitwise #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] gen_bit,
    output logic [N-1:0] prop_bit
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Local generate/propagate for position i.
        assign gen_bit[i]  = a[i] & b[i];
        assign prop_bit[i] = a[i] ^ b[i];
    end

endmodule

// File: rtl/ppx_black_cell.sv
// Module: ppx_black_cell
// Full merge cell: combines an upper span with the adjacent lower span,
// producing both group generate and group propagate.
module ppx_black_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    input  logic p_lo,
    output logic g_out,
    output logic p_out
);

    // Group generate: upper generates, or upper passes a lower generate.
    assign g_out = g_hi | (p_hi & g_lo);
    // Group propagate: both spans must pass the carry through.
    assign p_out = p_hi & p_lo;

endmodule

// File: rtl/ppx_gray_cell.sv
// Module: ppx_gray_cell
// Generate-only merge cell, used where the lower span already reaches
// the carry-in slot so the group propagate is known to be zero.
module ppx_gray_cell (
    input  logic g_hi,
    input  logic p_hi,
    input  logic g_lo,
    output logic g_out
);

    // Group generate toward the carry-in slot.
    assign g_out = g_hi | (p_hi & g_lo);

endmodule

// File: rtl/ppx_prefix_tree.sv
// Module: ppx_prefix_tree
// Minimum-depth, fanout-2 prefix network over N slots. Slot 0 holds the
// carry-in (generate = cin, propagate = 0); slot j holds bit j-1.
// At level k slot i merges with slot i-2^k. Slots below 2^k pass through.
// Slots below 2^(k+1) use generate-only cells. Output slot i is the carry
// into bit i. Assumes N is a power of two.
module ppx_prefix_tree #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] g_slot,
    input  logic [N-1:0] p_slot,
    output logic [N-1:0] carry_into
);

    localparam int unsigned LEVELS = ppx_pkg::tree_levels(N);

    logic [LEVELS:0][N-1:0] g_lv;
    logic [LEVELS:0][N-1:0] p_lv;
    logic                   unused_p_last;

    // Level 0 is the bitwise slot data.
    assign g_lv[0] = g_slot;
    assign p_lv[0] = p_slot;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int unsigned DIST = 1 << lv;
        for (genvar i = 0; i < N; i++) begin : g_slot_i
            if (i < DIST) begin : g_buf
                // Span already complete: carry forward unchanged.
                assign g_lv[lv+1][i] = g_lv[lv][i];
                assign p_lv[lv+1][i] = p_lv[lv][i];
            end else if (i < 2 * DIST) begin : g_gray
                // Lower span reaches slot 0: only generate is needed.
                ppx_gray_cell u_gray (
                    .g_hi  (g_lv[lv][i]),
                    .p_hi  (p_lv[lv][i]),
                    .g_lo  (g_lv[lv][i-DIST]),
                    .g_out (g_lv[lv+1][i])
                );
                assign p_lv[lv+1][i] = 1'b0;
            end else begin : g_black
                // Interior span: merge both terms.
                ppx_black_cell u_black (
                    .g_hi  (g_lv[lv][i]),
                    .p_hi  (p_lv[lv][i]),
                    .g_lo  (g_lv[lv][i-DIST]),
                    .p_lo  (p_lv[lv][i-DIST]),
                    .g_out (g_lv[lv+1][i]),
                    .p_out (p_lv[lv+1][i])
                );
            end
        end
    end

    // Final level: every slot spans to the carry-in.
    assign carry_into    = g_lv[LEVELS];
    assign unused_p_last = ^p_lv[LEVELS];

endmodule

// File: rtl/ppx_sum_stage.sv
// Module: ppx_sum_stage
// Produces sum bits from local propagate and the carry into each bit,
// and the carry-out from the top bit's terms and the carry into it.
module ppx_sum_stage #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] prop_bit,
    input  logic         gen_top,
    input  logic [N-1:0] carry_into,
    output logic [N-1:0] sum,
    output logic         cout
);

    // Sum: local propagate flipped by the incoming carry.
    assign sum = prop_bit ^ carry_into;

    // Carry-out: one more generate-only merge past the tree.
    ppx_gray_cell u_cout (
        .g_hi  (gen_top),
        .p_hi  (prop_bit[N-1]),
        .g_lo  (carry_into[N-1]),
        .g_out (cout)
    );

endmodule

// File: rtl/ppx_adder.sv
// Module: ppx_adder
// N-bit parallel-prefix adder. Combinational: {cout, sum} = a + b + cin.
// Assumes N is a power of two of at least 2. The carry-in occupies the
// lowest prefix slot, so the tree needs only log2 N levels.
module ppx_adder #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    logic [N-1:0] gen_bit;
    logic [N-1:0] prop_bit;
    logic [N-1:0] g_slot;
    logic [N-1:0] p_slot;
    logic [N-1:0] carry_into;

    ppx_pg_bitwise #(.N(N)) u_pg (
        .a        (a),
        .b        (b),
        .gen_bit  (gen_bit),
        .prop_bit (prop_bit)
    );

    // Slot map: carry-in at slot 0, bit j-1 at slot j.
    assign g_slot = {gen_bit[N-2:0], cin};
    assign p_slot = {prop_bit[N-2:0], 1'b0};

    ppx_prefix_tree #(.N(N)) u_tree (
        .g_slot     (g_slot),
        .p_slot     (p_slot),
        .carry_into (carry_into)
    );

    ppx_sum_stage #(.N(N)) u_sum (
        .prop_bit   (prop_bit),
        .gen_top    (gen_bit[N-1]),
        .carry_into (carry_into),
        .sum        (sum),
        .cout       (cout)
    );

endmodule

// File: rtl/ppx_adder_chk.sv
// Module: ppx_adder_chk
// Port-level checker bound into every ppx_adder instance. The adder has
// no clock, so the checks are immediate assertions on settled values.
module ppx_adder_chk #(
    parameter int unsigned N = 16
) (
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         cin,
    input logic [N-1:0] sum,
    input logic         cout
);

    logic [N:0] ref_total;

    // Wide reference sum used by the arithmetic check.
    always_comb ref_total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};

    // Relations between operands and results.
    always_comb begin
        a_r1_arith_total: assert ({cout, sum} == ref_total)
            else $error("R1: sum/cout disagree with a+b+cin");
        if (((a ^ b) == {N{1'b1}}) && cin)
            a_r3_full_propagate: assert ((sum == '0) && cout)
                else $error("R3: full-width carry lost");
        if ((b == '0) && !cin)
            a_r4_zero_addend: assert ((sum == a) && !cout)
                else $error("R4: identity add changed operand");
        if (a[N-1] && b[N-1])
            a_r5_top_generate: assert (cout)
                else $error("R5: top generate did not set cout");
        if (!a[N-1] && !b[N-1])
            a_r6_top_kill: assert (!cout)
                else $error("R6: top kill did not clear cout");
    end

endmodule

bind ppx_adder ppx_adder_chk #(.N(N)) u_ppx_adder_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/ppx_adder_bench.sv
// Bench: drives a 16-bit and a 4-bit adder, and compares both outputs
// against a behavioural integer model on every clock.
module ppx_adder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WIDE       = 16;
    localparam int NARROW     = 4;
    localparam int WATCHDOG   = 50000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;

    logic [WIDE-1:0]   a_w = '0, b_w = '0, sum_w;
    logic              cin_w = 1'b0, cout_w;
    logic [NARROW-1:0] a_n = '0, b_n = '0, sum_n;
    logic              cin_n = 1'b0, cout_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppx_adder #(.N(WIDE)) u_ppx_adder (
        .a(a_w), .b(b_w), .cin(cin_w), .sum(sum_w), .cout(cout_w)
    );

    ppx_adder #(.N(NARROW)) u_ppx_adder_small (
        .a(a_n), .b(b_n), .cin(cin_n), .sum(sum_n), .cout(cout_n)
    );

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected <= %0d)",
                     WATCHDOG, cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Apply one 16-bit vector at posedge, compare at negedge.
    task automatic wide_vec(input logic [WIDE-1:0] av, input logic [WIDE-1:0] bv,
                            input logic cv, input string req);
        longint unsigned expv;
        @(posedge clk);
        a_w = av; b_w = bv; cin_w = cv;
        @(negedge clk);
        expv = longint'(av) + longint'(bv) + longint'(cv);
        checks++;
        if ({cout_w, sum_w} != expv[WIDE:0]) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, av, bv, cv, {cout_w, sum_w}, expv[WIDE:0]);
        end
    endtask

    // Apply one 4-bit vector at posedge, compare at negedge.
    task automatic narrow_vec(input int av, input int bv, input int cv);
        int expv;
        @(posedge clk);
        a_n = av[NARROW-1:0]; b_n = bv[NARROW-1:0]; cin_n = cv[0];
        @(negedge clk);
        expv = av + bv + cv;
        checks++;
        if ({cout_n, sum_n} != expv[NARROW:0]) begin
            fails++;
            $display("FAIL R2: a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
                     av, bv, cv, {cout_n, sum_n}, expv);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all-zero inputs give zero outputs (R1).
        @(negedge clk);
        checks++;
        if ({cout_w, sum_w} != '0) begin
            fails++;
            $display("FAIL R1 reset: actual=%h expected=0", {cout_w, sum_w});
        end

        // R7: carry-in alone.
        wide_vec(16'h0000, 16'h0000, 1'b1, "R7");
        // R3: full-width propagation patterns.
        wide_vec(16'hFFFF, 16'h0000, 1'b1, "R3");
        wide_vec(16'h0000, 16'hFFFF, 1'b1, "R3");
        wide_vec(16'h5555, 16'hAAAA, 1'b1, "R3");
        wide_vec(16'h0F0F, 16'hF0F0, 1'b1, "R3");
        wide_vec(16'hFFFF, 16'hFFFF, 1'b1, "R1 max");
        // R4: zero addend.
        wide_vec(16'h1234, 16'h0000, 1'b0, "R4");
        wide_vec(16'hFFFF, 16'h0000, 1'b0, "R4");
        // R5: top generate with lower bits killing.
        wide_vec(16'h8000, 16'h8000, 1'b0, "R5");
        // R6: top kill with lower bits all propagating.
        wide_vec(16'h7FFF, 16'h0000, 1'b1, "R6");
        wide_vec(16'h7FFF, 16'h7FFF, 1'b1, "R6");

        // R1: random vectors.
        for (int k = 0; k < 3000; k++) begin
            wide_vec(16'($urandom), 16'($urandom), 1'($urandom), "R1");
        end

        // R2: exhaustive at width 4.
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    narrow_vec(x, y, c);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule